// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This unit is the hazard control for a six-stage, 32-bit in-order pipeline. The stages run in the order FE1, FE2, REG, EXMEM1, EXMEM2, WB. FE2 handles instruction-cache misses. Register operands are read in REG. EXMEM1 does the execution and the data-cache access. EXMEM2 completes multi-cycle ALU operations and handles data-cache misses. The unit is purely combinational apart from its checks. For each source operand of the instruction in EXMEM1, it chooses the value to use: the register-file value, the result held in EXMEM2, or the result held in WB. It compares each source register number against the destinations of the two older instructions to make that choice. Register 0 is hardwired to zero and never takes part in forwarding or dependency checks.

The unit also produces one stall bit and one flush bit per stage. Bit i of each vector acts on the pipeline register that feeds stage i at the next clock edge, with FE1 = 0, FE2 = 1, REG = 2, EXMEM1 = 3, EXMEM2 = 4 and WB = 5. A set stall bit makes that register keep its contents. A set flush bit makes it load a bubble: valid cleared and the destination write-enable suppressed.

Each cycle falls into exactly one of five named modes, chosen by fixed priority:
- BACK: the back end is busy.
- DEP: an operand dependency cannot be bypassed.
- JUMP: a taken branch or jump is resolved in EXMEM1.
- IFILL: an instruction-cache miss is in progress.
- RUN: no hazard.

There is no state register. The mode is recomputed every cycle from the inputs, and the mode alone sets the stall and flush vectors.

Top module: `hazard_unit`

## Requirements
- R1: For operand k (source field `x1_src[4k+3:4k]`), the select `fwd_sel[2k+1:2k]` is 1 (take the EXMEM2 result) when all of the following hold: `x1_valid`, `x2_valid` and `x2_we` are high, and `x2_rd` equals the nonzero source number.
- R2: When R1 does not apply, the select is 2 (take the WB result) when all of the following hold: `x1_valid`, `wb_valid` and `wb_we` are high, and `wb_rd` equals the nonzero source number.
- R3: When both EXMEM2 and WB write the operand's source register, the select is 1, so the younger EXMEM2 value wins.
- R4: The select is 0 (register-file value) in any of these cases:
  - the source number is 0;
  - `x1_valid` is low;
  - neither later stage matches.
  A destination of 0 therefore never forwards.
- R5: In mode DEP, `stall` = 6'b001111 and `flush` = 6'b010000. This holds FE1 to EXMEM1 and puts a bubble into EXMEM2. DEP applies when an operand matches EXMEM2 as in R1 while `x2_ready` is low.
- R6: A match in EXMEM2 with `x2_ready` high is bypassed without any stall or flush.
- R7: In mode BACK, `stall` = 6'b011111 and `flush` = 6'b100000. BACK applies when `x2_valid` is high together with `x2_mc_busy` or `x2_dmiss`. BACK takes priority over DEP.
- R8: In mode IFILL, `stall` = 6'b000011 and `flush` = 6'b000100. IFILL applies when `f2_imiss` is high and no other hazard is present.
- R9: In mode JUMP, `stall` = 6'b000000 and `flush` = 6'b001110. JUMP applies when `x1_valid` and `x1_redirect` are high. This flushes the three younger instructions and lets FE1 load the target. JUMP overrides IFILL in the same cycle: flush beats stall.
- R10: `x1_redirect` has no effect while mode BACK or DEP applies; the outputs are those of R7 or R5. No stall bit is ever set together with the flush bit of the same stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used by the checks |
| rst_n | input | 1 | Active-low reset, used by the checks |
| x1_valid | input | 1 | EXMEM1 holds a valid instruction |
| x1_src | input | 8 | EXMEM1 source register numbers, operand k in bits 4k+3:4k |
| x1_redirect | input | 1 | EXMEM1 resolved a taken branch or jump |
| x2_valid | input | 1 | EXMEM2 holds a valid instruction |
| x2_we | input | 1 | EXMEM2 instruction writes a register |
| x2_rd | input | 4 | EXMEM2 destination register |
| x2_ready | input | 1 | EXMEM2 result is available for bypass |
| x2_mc_busy | input | 1 | Multi-cycle ALU operation still running in EXMEM2 |
| x2_dmiss | input | 1 | Data-cache miss pending in EXMEM2 |
| wb_valid | input | 1 | WB holds a valid instruction |
| wb_we | input | 1 | WB instruction writes a register |
| wb_rd | input | 4 | WB destination register |
| f2_imiss | input | 1 | Instruction-cache miss pending in FE2 |
| fwd_sel | output | 4 | Operand selects, 2 bits each: 0 register file, 1 EXMEM2, 2 WB |
| stall | output | 6 | Per-stage hold, bit 0 FE1 through bit 5 WB |
| flush | output | 6 | Per-stage bubble insert, same bit order |

## Verification
Two functions can meet in one cycle: a taken redirect in EXMEM1 and an instruction-cache miss in FE2. In that cycle the flush of the younger instructions must win over the front-end stall. The bench raises `f2_imiss` and `x1_redirect` in the same cycle. It expects the JUMP vectors, with FE1 and FE2 not stalled. It then repeats the redirect alongside a multi-cycle busy signal and alongside an unready EXMEM2 dependency. In those cases the redirect must be deferred and produce the BACK or DEP vectors. A mix of forwarding patterns is checked in the same cycles, so the selects are judged while the stall logic is active.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        SRC_RF = 2'd0,
        SRC_X2 = 2'd1,
        SRC_WB = 2'd2
    } src_e;

    typedef enum logic [2:0] {
        M_RUN   = 3'd0,
        M_BACK  = 3'd1,
        M_DEP   = 3'd2,
        M_JUMP  = 3'd3,
        M_IFILL = 3'd4
    } mode_e;

    localparam int NSTG   = 6;
    localparam int ST_FE1 = 0;
    localparam int ST_FE2 = 1;
    localparam int ST_REG = 2;
    localparam int ST_X1  = 3;
    localparam int ST_X2  = 4;
    localparam int ST_WB  = 5;

endpackage

// File: rtl/hz_bypass.sv
module hz_bypass
    import hz_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] src,
    input  logic          x1_valid,
    input  logic          x2_wr,
    input  logic [AW-1:0] x2_rd,
    input  logic          wb_wr,
    input  logic [AW-1:0] wb_rd,
    output src_e          sel,
    output logic          x2_hit
);

    logic reads_reg;
    logic wb_hit;

    assign reads_reg = x1_valid && (src != '0);
    assign x2_hit    = reads_reg && x2_wr && (x2_rd == src);
    assign wb_hit    = reads_reg && wb_wr && (wb_rd == src);

    always_comb begin
        if (x2_hit)      sel = SRC_X2;
        else if (wb_hit) sel = SRC_WB;
        else             sel = SRC_RF;
    end

    // R4
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> (sel == SRC_RF));

    // R3
    younger_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x1_valid && src != '0 && x2_wr && x2_rd == src) |-> (sel == SRC_X2));

endmodule

// File: rtl/hz_mode.sv
module hz_mode
    import hz_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  back_busy,
    input  logic  dep_wait,
    input  logic  redir,
    input  logic  imiss,
    output mode_e mode
);

    always_comb begin
        if (back_busy)     mode = M_BACK;
        else if (dep_wait) mode = M_DEP;
        else if (redir)    mode = M_JUMP;
        else if (imiss)    mode = M_IFILL;
        else               mode = M_RUN;
    end

    // R7
    back_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        back_busy |-> (mode == M_BACK));

endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  mode_e           mode,
    output logic [NSTG-1:0] stall,
    output logic [NSTG-1:0] flush
);

    always_comb begin
        stall = '0;
        flush = '0;
        unique case (mode)
            M_RUN: begin
            end
            M_BACK: begin
                for (int i = ST_FE1; i <= ST_X2; i++) stall[i] = 1'b1;
                flush[ST_WB] = 1'b1;
            end
            M_DEP: begin
                for (int i = ST_FE1; i <= ST_X1; i++) stall[i] = 1'b1;
                flush[ST_X2] = 1'b1;
            end
            M_JUMP: begin
                for (int i = ST_FE2; i <= ST_X1; i++) flush[i] = 1'b1;
            end
            M_IFILL: begin
                stall[ST_FE1] = 1'b1;
                stall[ST_FE2] = 1'b1;
                flush[ST_REG] = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall & flush) == '0);

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hz_pkg::*;
#(
    parameter int AW   = 4,
    parameter int NSRC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              x1_valid,
    input  logic [NSRC*AW-1:0] x1_src,
    input  logic              x1_redirect,
    input  logic              x2_valid,
    input  logic              x2_we,
    input  logic [AW-1:0]     x2_rd,
    input  logic              x2_ready,
    input  logic              x2_mc_busy,
    input  logic              x2_dmiss,
    input  logic              wb_valid,
    input  logic              wb_we,
    input  logic [AW-1:0]     wb_rd,
    input  logic              f2_imiss,
    output logic [2*NSRC-1:0] fwd_sel,
    output logic [NSTG-1:0]   stall,
    output logic [NSTG-1:0]   flush
);

    logic [NSRC-1:0] x2_hit;
    logic            x2_wr, wb_wr;
    logic            back_busy, dep_wait, redir;
    mode_e           mode;

    assign x2_wr = x2_valid && x2_we;
    assign wb_wr = wb_valid && wb_we;

    for (genvar k = 0; k < NSRC; k++) begin : g_op
        src_e sel_k;
        hz_bypass #(.AW(AW)) u_byp (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (x1_src[k*AW +: AW]),
            .x1_valid (x1_valid),
            .x2_wr    (x2_wr),
            .x2_rd    (x2_rd),
            .wb_wr    (wb_wr),
            .wb_rd    (wb_rd),
            .sel      (sel_k),
            .x2_hit   (x2_hit[k])
        );
        assign fwd_sel[2*k +: 2] = sel_k;
    end

    assign back_busy = x2_valid && (x2_mc_busy || x2_dmiss);
    assign dep_wait  = (|x2_hit) && !x2_ready;
    assign redir     = x1_valid && x1_redirect;

    hz_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .back_busy (back_busy),
        .dep_wait  (dep_wait),
        .redir     (redir),
        .imiss     (f2_imiss),
        .mode      (mode)
    );

    hz_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .stall (stall),
        .flush (flush)
    );

    // R5
    dep_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x1_valid && x2_valid && x2_we && x2_rd != '0 && x2_rd == x1_src[AW-1:0]
         && !x2_ready && !(x2_mc_busy || x2_dmiss)) |-> (stall[ST_X1] && flush[ST_X2]));

    // R7
    back_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x2_valid && x2_dmiss) |-> (stall[ST_X2] && flush[ST_WB] && !flush[ST_X1]));

    // R6
    ready_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel[1:0] == 2'd1 && x2_ready && !x2_mc_busy && !x2_dmiss && !f2_imiss)
        |-> (stall == '0));

endmodule

// File: tb/sim_hazard_unit.sv
module sim_hazard_unit;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       x1_valid, x1_redirect, x2_valid, x2_we, x2_ready;
    logic       x2_mc_busy, x2_dmiss, wb_valid, wb_we, f2_imiss;
    logic [7:0] x1_src;
    logic [3:0] x2_rd, wb_rd;
    logic [3:0] fwd_sel;
    logic [5:0] stall, flush;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    hazard_unit u0 (
        .clk(clk), .rst_n(rst_n), .x1_valid(x1_valid), .x1_src(x1_src),
        .x1_redirect(x1_redirect), .x2_valid(x2_valid), .x2_we(x2_we),
        .x2_rd(x2_rd), .x2_ready(x2_ready), .x2_mc_busy(x2_mc_busy),
        .x2_dmiss(x2_dmiss), .wb_valid(wb_valid), .wb_we(wb_we), .wb_rd(wb_rd),
        .f2_imiss(f2_imiss), .fwd_sel(fwd_sel), .stall(stall), .flush(flush)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic idle();
        x1_valid = 0; x1_src = 0; x1_redirect = 0; x2_valid = 0; x2_we = 0;
        x2_rd = 0; x2_ready = 1; x2_mc_busy = 0; x2_dmiss = 0;
        wb_valid = 0; wb_we = 0; wb_rd = 0; f2_imiss = 0;
    endtask

    task automatic setup(logic [3:0] s1, logic [3:0] s0, logic [3:0] xd, logic [3:0] wd);
        @(negedge clk);
        idle();
        x1_valid = 1; x1_src = {s1, s0};
        x2_valid = 1; x2_we = 1; x2_rd = xd;
        wb_valid = 1; wb_we = 1; wb_rd = wd;
    endtask

    task automatic t_reset();
        chk("reset R4 fwd", {4'd0, fwd_sel}, 8'd0);
        chk("reset R10 stall", {2'd0, stall}, 8'd0);
        chk("reset R10 flush", {2'd0, flush}, 8'd0);
    endtask

    task automatic t_forward();
        setup(4'd7, 4'd3, 4'd3, 4'd7); #1;
        chk("R1 op0 from x2 / R2 op1 from wb", {4'd0, fwd_sel}, 8'b0000_1001);
        chk("R6 no stall on ready bypass", {2'd0, stall}, 8'd0);
        setup(4'd5, 4'd5, 4'd5, 4'd5); #1;
        chk("R3 both stages match", {4'd0, fwd_sel}, 8'b0000_0101);
        setup(4'd0, 4'd0, 4'd0, 4'd0); #1;
        chk("R4 source zero", {4'd0, fwd_sel}, 8'd0);
        setup(4'd2, 4'd9, 4'd4, 4'd6); #1;
        chk("R4 no match", {4'd0, fwd_sel}, 8'd0);
        setup(4'd2, 4'd2, 4'd2, 4'd2); x1_valid = 0; #1;
        chk("R4 x1 invalid", {4'd0, fwd_sel}, 8'd0);
        setup(4'd2, 4'd8, 4'd2, 4'd8); x2_we = 0; wb_valid = 0; #1;
        chk("R2 x2 no write, wb invalid", {4'd0, fwd_sel}, 8'd0);
    endtask

    task automatic t_dep();
        setup(4'd1, 4'd4, 4'd4, 4'd0); x2_ready = 0; #1;
        chk("R5 dep stall", {2'd0, stall}, 8'b0000_1111);
        chk("R5 dep flush", {2'd0, flush}, 8'b0001_0000);
        setup(4'd4, 4'd1, 4'd4, 4'd0); x2_ready = 0; #1;
        chk("R5 dep via op1 stall", {2'd0, stall}, 8'b0000_1111);
        setup(4'd1, 4'd2, 4'd0, 4'd2); x2_ready = 0; #1;
        chk("R5 wb match only no stall", {2'd0, stall}, 8'd0);
    endtask

    task automatic t_back();
        setup(4'd1, 4'd2, 4'd9, 4'd9); x2_mc_busy = 1; #1;
        chk("R7 mc stall", {2'd0, stall}, 8'b0001_1111);
        chk("R7 mc flush", {2'd0, flush}, 8'b0010_0000);
        setup(4'd1, 4'd2, 4'd2, 4'd9); x2_dmiss = 1; x2_ready = 0; #1;
        chk("R7 dmiss beats dep stall", {2'd0, stall}, 8'b0001_1111);
        chk("R7 dmiss beats dep flush", {2'd0, flush}, 8'b0010_0000);
    endtask

    task automatic t_front();
        @(negedge clk); idle(); f2_imiss = 1; #1;
        chk("R8 imiss stall", {2'd0, stall}, 8'b0000_0011);
        chk("R8 imiss flush", {2'd0, flush}, 8'b0000_0100);
        @(negedge clk); idle(); x1_valid = 1; x1_redirect = 1; #1;
        chk("R9 jump stall", {2'd0, stall}, 8'd0);
        chk("R9 jump flush", {2'd0, flush}, 8'b0000_1110);
        @(negedge clk); idle(); x1_valid = 1; x1_redirect = 1; f2_imiss = 1; #1;
        chk("R9 jump over imiss stall", {2'd0, stall}, 8'd0);
        chk("R9 jump over imiss flush", {2'd0, flush}, 8'b0000_1110);
        @(negedge clk); idle(); x1_redirect = 1; #1;
        chk("R9 redirect needs valid", {2'd0, flush}, 8'd0);
    endtask

    task automatic t_defer();
        setup(4'd1, 4'd2, 4'd9, 4'd9); x2_mc_busy = 1; x1_redirect = 1; #1;
        chk("R10 redirect under back stall", {2'd0, stall}, 8'b0001_1111);
        chk("R10 redirect under back flush", {2'd0, flush}, 8'b0010_0000);
        setup(4'd1, 4'd2, 4'd2, 4'd9); x2_ready = 0; x1_redirect = 1; f2_imiss = 1; #1;
        chk("R10 redirect under dep stall", {2'd0, stall}, 8'b0000_1111);
        chk("R10 redirect under dep flush", {2'd0, flush}, 8'b0001_0000);
        chk("R1 select during dep", {4'd0, fwd_sel}, 8'b0000_0001);
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_forward();
        t_dep();
        t_back();
        t_front();
        t_defer();
        @(negedge clk); idle();
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule